// File: doc/BRIEF.md
# Fractional-Rate Multi-Group Pacing Timer

This block paces many traffic groups from one shared master tick. Each group owns a table entry with an integer down-counter, a 16-bit fractional accumulator and a pair of programmed rates: an integer part and a fraction in units of 1/65536. Every master tick starts a walk through the table, from entry 0 up to a programmable last entry. The walk visits one entry per clock cycle. Each enabled entry it visits counts down by one. When an entry's count reaches zero, the block issues a one-cycle service strobe that carries the group number. The entry then reloads from its rates.

The fraction is added into the accumulator at every reload. When that addition wraps, the carry makes the next interval one tick longer. Over time, the average spacing of service strobes therefore equals the programmed integer-plus-fraction rate. Software derives the rates from the aggregate cell rate and the link count; the block only stores them. A tick that arrives while a walk is still in progress is counted and served by a later walk, so no tick is ever lost.

Top module: `pace_timer_bank`

## Requirements
- R1: Each master tick causes exactly one walk over entries 0..last, one entry per cycle. Service strobes within a walk appear in strictly ascending group order, each one cycle after its entry is visited.
- R2: A visit to an enabled entry decrements its integer count by one. When the result is zero, `svcValid` is high for one cycle and `svcGroup` holds that entry's index.
- R3: On a service event, the fractional rate is added to the 16-bit accumulator. The count reloads with the integer rate plus the carry out of that addition. Example: with integer 2 and fraction 0x8000, ten ticks produce events on ticks 2, 4, 7 and 9.
- R4: An integer rate of 0 behaves as 1, so such an entry fires on every tick.
- R5: Disabled entries (`cfgEn`=0 in their last write) never produce service events.
- R6: Any write with `cfgWe`=1 stores the rates and the enable for entry `cfgIdx`, loads the count from the effective integer rate, and clears the accumulator.
- R7: A last-index write above DEPTH-1 is clamped to DEPTH-1, so `svcGroup` never exceeds DEPTH-1.
- R8: Ticks that arrive during a walk are queued (up to 2^PEND_W-1 of them) and each one starts its own later walk. `busy` is high the cycle after any tick.
- R9: After reset, `svcValid` and `busy` are low, all entries are disabled, and the last index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickIn | input | 1 | Master pacing tick, one per cycle high |
| cfgWe | input | 1 | Entry write strobe |
| cfgIdx | input | IDX_W | Entry being written |
| cfgEn | input | 1 | Enable value for the written entry |
| cfgIntRate | input | RATE_W | Integer request rate |
| cfgFracRate | input | RATE_W | Fractional request rate (value/65536) |
| lastWe | input | 1 | Last-index write strobe |
| lastIdx | input | IDX_W | Highest entry visited per walk |
| svcValid | output | 1 | One-cycle service strobe |
| svcGroup | output | IDX_W | Group index of the service strobe |
| busy | output | 1 | Walk in progress or ticks pending |

## Verification
The assertions assume three things about the inputs. Entry and last-index writes arrive only while `busy` is low, so a write never races a walk. The tick backlog never reaches the saturating pending limit. Ticks stay separated enough that two walks never run back to back without an idle cycle between them, which the control already guarantees.

The bench keeps within these assumptions. It performs all configuration only after waiting for `busy` to fall. It issues ticks in bursts of at most three per walk, which stays far below the backlog limit.

// File: rtl/pace_pkg.sv
package pace_pkg;
  // Strobes from the scan control to the entry datapath.
  typedef struct packed {
    logic step;      // visit the entry at stepIdx this cycle
    logic cfgWrite;  // load the entry at cfgIdx from the config inputs
  } paceCtrl_t;
endpackage

// File: rtl/pace_control.sv
module pace_control
  import pace_pkg::*;
#(
  parameter int DEPTH  = 24,
  parameter int IDX_W  = 5,
  parameter int PEND_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  logic             cfgWe,
  input  logic             lastWe,
  input  logic [IDX_W-1:0] lastIdx,
  output paceCtrl_t        ctrl,
  output logic [IDX_W-1:0] stepIdx,
  output logic             busy
);
  localparam logic [IDX_W-1:0]  LAST_MAX = IDX_W'(DEPTH - 1);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic              scanning;
  logic [IDX_W-1:0]  scanIdx;
  logic [IDX_W-1:0]  scanLast;
  logic [IDX_W-1:0]  lastReg;
  logic [PEND_W-1:0] pendCnt;
  logic [PEND_W-1:0] pendNext;
  logic              start;

  assign start = !scanning && (tickIn || (pendCnt != '0));

  always_comb begin
    pendNext = pendCnt;
    if (tickIn && !start) begin
      pendNext = (pendCnt == PEND_MAX) ? pendCnt : pendCnt + 1'b1;
    end else if (!tickIn && start) begin
      pendNext = pendCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanning <= 1'b0;
      scanIdx  <= '0;
      scanLast <= '0;
      lastReg  <= '0;
      pendCnt  <= '0;
    end else begin
      pendCnt <= pendNext;
      if (lastWe) lastReg <= (lastIdx > LAST_MAX) ? LAST_MAX : lastIdx;
      if (start) begin
        scanning <= 1'b1;
        scanIdx  <= '0;
        scanLast <= lastReg;
      end else if (scanning) begin
        if (scanIdx == scanLast) scanning <= 1'b0;
        else                     scanIdx  <= scanIdx + 1'b1;
      end
    end
  end

  assign ctrl.step     = scanning;
  assign ctrl.cfgWrite = cfgWe;
  assign stepIdx       = scanIdx;
  assign busy          = scanning || (pendCnt != '0);
endmodule

// File: rtl/pace_datapath.sv
module pace_datapath
  import pace_pkg::*;
#(
  parameter int DEPTH  = 24,
  parameter int IDX_W  = 5,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  paceCtrl_t         ctrl,
  input  logic [IDX_W-1:0]  stepIdx,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic              cfgEn,
  input  logic [RATE_W-1:0] cfgIntRate,
  input  logic [RATE_W-1:0] cfgFracRate,
  output logic              svcValid,
  output logic [IDX_W-1:0]  svcGroup
);
  localparam int CNT_W = RATE_W + 1;

  logic [CNT_W-1:0]  cnt   [DEPTH];
  logic [RATE_W-1:0] frac  [DEPTH];
  logic [RATE_W-1:0] rateI [DEPTH];
  logic [RATE_W-1:0] rateF [DEPTH];
  logic [DEPTH-1:0]  en;

  function automatic logic [RATE_W-1:0] effRate(input logic [RATE_W-1:0] r);
    return (r == '0) ? RATE_W'(1) : r;
  endfunction

  // Shared arithmetic for the entry currently being visited.
  logic [CNT_W-1:0]  decCnt;
  logic [RATE_W:0]   fracSum;
  logic [CNT_W-1:0]  reloadCnt;
  logic              hit;

  assign decCnt    = cnt[stepIdx] - 1'b1;
  assign fracSum   = {1'b0, frac[stepIdx]} + {1'b0, rateF[stepIdx]};
  assign reloadCnt = {1'b0, effRate(rateI[stepIdx])} + CNT_W'(fracSum[RATE_W]);
  assign hit       = ctrl.step && en[stepIdx] && (decCnt == '0);

  for (genvar i = 0; i < DEPTH; i++) begin : gEntry
    logic selCfg;
    logic selStep;
    assign selCfg  = ctrl.cfgWrite && (cfgIdx == IDX_W'(i));
    assign selStep = ctrl.step && (stepIdx == IDX_W'(i)) && en[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt[i]   <= CNT_W'(1);
        frac[i]  <= '0;
        rateI[i] <= '0;
        rateF[i] <= '0;
        en[i]    <= 1'b0;
      end else if (selCfg) begin
        en[i]    <= cfgEn;
        rateI[i] <= cfgIntRate;
        rateF[i] <= cfgFracRate;
        cnt[i]   <= {1'b0, effRate(cfgIntRate)};
        frac[i]  <= '0;
      end else if (selStep) begin
        if (decCnt == '0) begin
          cnt[i]  <= reloadCnt;
          frac[i] <= fracSum[RATE_W-1:0];
        end else begin
          cnt[i]  <= decCnt;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svcValid <= 1'b0;
      svcGroup <= '0;
    end else begin
      svcValid <= hit;
      if (hit) svcGroup <= stepIdx;
    end
  end
endmodule

// File: rtl/pace_timer_bank.sv
module pace_timer_bank
  import pace_pkg::*;
#(
  parameter int DEPTH  = 24,
  parameter int RATE_W = 16,
  parameter int PEND_W = 4,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic              cfgEn,
  input  logic [RATE_W-1:0] cfgIntRate,
  input  logic [RATE_W-1:0] cfgFracRate,
  input  logic              lastWe,
  input  logic [IDX_W-1:0]  lastIdx,
  output logic              svcValid,
  output logic [IDX_W-1:0]  svcGroup,
  output logic              busy
);
  paceCtrl_t        ctrl;
  logic [IDX_W-1:0] stepIdx;

  pace_control #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PEND_W(PEND_W)) uCtrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .cfgWe(cfgWe),
    .lastWe(lastWe), .lastIdx(lastIdx),
    .ctrl(ctrl), .stepIdx(stepIdx), .busy(busy)
  );

  pace_datapath #(.DEPTH(DEPTH), .IDX_W(IDX_W), .RATE_W(RATE_W)) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .stepIdx(stepIdx),
    .cfgIdx(cfgIdx), .cfgEn(cfgEn), .cfgIntRate(cfgIntRate),
    .cfgFracRate(cfgFracRate), .svcValid(svcValid), .svcGroup(svcGroup)
  );
endmodule

// File: rtl/pace_checker.sv
module pace_checker #(
  parameter int DEPTH = 24,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickIn,
  input logic             svcValid,
  input logic [IDX_W-1:0] svcGroup,
  input logic             busy
);
  assert_group_in_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    svcValid |-> (int'(svcGroup) <= DEPTH - 1));

  assert_ascending_order_R1: assert property (@(posedge clk) disable iff (!rstN)
    (svcValid && $past(svcValid)) |-> (svcGroup == IDX_W'($past(svcGroup) + 1'b1)));

  assert_event_within_scan_R2: assert property (@(posedge clk) disable iff (!rstN)
    svcValid |-> $past(busy));

  assert_tick_not_dropped_R8: assert property (@(posedge clk) disable iff (!rstN)
    tickIn |=> busy);
endmodule

bind pace_timer_bank pace_checker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .tickIn(tickIn),
  .svcValid(svcValid), .svcGroup(svcGroup), .busy(busy)
);

// File: tb/tb_pace_timer_bank.sv
module tb_pace_timer_bank;
  localparam int DEPTH = 24;
  localparam int RATE_W = 16;
  localparam int IDX_W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickIn = 1'b0, cfgWe = 1'b0, cfgEn = 1'b0, lastWe = 1'b0;
  logic [IDX_W-1:0] cfgIdx = '0, lastIdx = '0;
  logic [RATE_W-1:0] cfgIntRate = '0, cfgFracRate = '0;
  logic svcValid, busy;
  logic [IDX_W-1:0] svcGroup;

  always #2.5 clk = ~clk;

  pace_timer_bank dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgEn(cfgEn), .cfgIntRate(cfgIntRate), .cfgFracRate(cfgFracRate),
    .lastWe(lastWe), .lastIdx(lastIdx), .svcValid(svcValid),
    .svcGroup(svcGroup), .busy(busy)
  );

  int testCnt = 0, failCnt = 0;
  bit done = 0;
  int mCnt[DEPTH], mFrac[DEPTH], mRateI[DEPTH], mRateF[DEPTH];
  bit mEn[DEPTH];
  int mLast = 0;
  int expQ[$], obsQ[$];

  always @(negedge clk) if (rstN && svcValid) obsQ.push_back(int'(svcGroup));

  task automatic check(bit ok, string req, string what, int act, int expv);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int eff(int r);
    return (r == 0) ? 1 : r;
  endfunction

  task automatic modelScan();
    for (int i = 0; i <= mLast; i++) begin
      if (mEn[i]) begin
        mCnt[i]--;
        if (mCnt[i] == 0) begin
          int s;
          expQ.push_back(i);
          s = mFrac[i] + mRateF[i];
          mFrac[i] = s & 16'hFFFF;
          mCnt[i] = eff(mRateI[i]) + (s >> 16);
        end
      end
    end
  endtask

  task automatic writeEntry(int idx, bit en, int ri, int rf);
    @(negedge clk);
    cfgWe = 1; cfgIdx = IDX_W'(idx); cfgEn = en;
    cfgIntRate = RATE_W'(ri); cfgFracRate = RATE_W'(rf);
    @(negedge clk);
    cfgWe = 0;
    mEn[idx] = en; mRateI[idx] = ri; mRateF[idx] = rf;
    mCnt[idx] = eff(ri); mFrac[idx] = 0;
  endtask

  task automatic setLast(int v);
    @(negedge clk);
    lastWe = 1; lastIdx = IDX_W'(v);
    @(negedge clk);
    lastWe = 0;
    mLast = (v > DEPTH - 1) ? DEPTH - 1 : v;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulseTicks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tickIn = 1;
    end
    @(negedge clk); tickIn = 0;
    for (int k = 0; k < n; k++) modelScan();
    waitIdle();
  endtask

  task automatic compareEvents(string req);
    check(obsQ.size() == expQ.size(), req, "event count", obsQ.size(), expQ.size());
    for (int k = 0; k < expQ.size() && k < obsQ.size(); k++)
      check(obsQ[k] == expQ[k], req, "event group", obsQ[k], expQ[k]);
    obsQ.delete(); expQ.delete();
  endtask

  task automatic disableAll();
    for (int i = 0; i < DEPTH; i++) writeEntry(i, 0, 1, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testCnt++; failCnt++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mEn[i] = 0; mCnt[i] = 1; mFrac[i] = 0; mRateI[i] = 0; mRateF[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R9 reset state
    check(svcValid == 0, "R9", "svcValid in reset", svcValid, 0);
    check(busy == 0, "R9", "busy in reset", busy, 0);
    rstN = 1;
    @(negedge clk);
    pulseTicks(1);
    check(obsQ.size() == 0, "R9", "events after reset tick", obsQ.size(), 0);
    compareEvents("R9");

    // R3 fractional carry: int 2, frac 0x8000, ten ticks -> 4 events
    writeEntry(0, 1, 2, 16'h8000);
    setLast(0);
    for (int t = 0; t < 10; t++) pulseTicks(1);
    check(obsQ.size() == 4, "R3", "events in ten ticks", obsQ.size(), 4);
    compareEvents("R3");

    // R6 rewrite reloads count and clears accumulator: next fire after 2 ticks
    writeEntry(0, 1, 2, 16'h8000);
    pulseTicks(1);
    check(obsQ.size() == 0, "R6", "no event one tick after reload", obsQ.size(), 0);
    pulseTicks(1);
    check(obsQ.size() == 1, "R6", "event two ticks after reload", obsQ.size(), 1);
    compareEvents("R6");

    // R4 zero integer rate fires each tick
    writeEntry(0, 1, 0, 0);
    for (int t = 0; t < 5; t++) pulseTicks(1);
    check(obsQ.size() == 5, "R4", "events with zero rate", obsQ.size(), 5);
    compareEvents("R4");

    // R5 disabled entry silent, R7 clamp of last index
    for (int i = 0; i < DEPTH; i++) writeEntry(i, (i != 3), 1, 0);
    setLast(31);
    pulseTicks(1);
    check(obsQ.size() == DEPTH - 1, "R7", "events with clamped last", obsQ.size(), DEPTH - 1);
    begin
      bit saw3 = 0;
      int maxG = 0;
      foreach (obsQ[k]) begin
        if (obsQ[k] == 3) saw3 = 1;
        if (obsQ[k] > maxG) maxG = obsQ[k];
      end
      check(saw3 == 0, "R5", "disabled entry fired", saw3, 0);
      check(maxG == DEPTH - 1, "R7", "highest group", maxG, DEPTH - 1);
    end
    compareEvents("R7");

    // R8 back-to-back ticks during a scan each produce a walk
    pulseTicks(3);
    check(obsQ.size() == 3 * (DEPTH - 1), "R8", "events from queued ticks", obsQ.size(), 3 * (DEPTH - 1));
    compareEvents("R8");

    // R1 R2 R3 constrained random against the model
    void'($urandom(32'd20240611));
    for (int round = 0; round < 8; round++) begin
      for (int i = 0; i < DEPTH; i++)
        writeEntry(i, ($urandom_range(0, 3) != 0), $urandom_range(0, 4), $urandom_range(0, 65535));
      setLast($urandom_range(0, 31));
      for (int p = 0; p < 6; p++) begin
        pulseTicks($urandom_range(1, 3));
        compareEvents("R1");
      end
    end

    // R2 single-cycle strobe: a lone entry with rate 1 gives one event per tick
    disableAll();
    writeEntry(5, 1, 1, 0);
    setLast(10);
    pulseTicks(2);
    check(obsQ.size() == 2, "R2", "single-cycle strobes", obsQ.size(), 2);
    compareEvents("R2");

    finishRun();
  end
endmodule